// File: doc/BRIEF.md
# Codec Power-Down and Link Reset Sequencer

This block owns the power-down control/status word of an audio codec. The upper byte holds one power-down request per internal section (ADC path, DAC path, mixer, voltage reference, serial link, internal clocks) plus a bit that drives the external amplifier shutdown pin directly. The low nibble reports, per analog section, whether that section has settled after being powered up, so software can poll it before using the section.

Stopping the serial link is handled with care. A request to stop it is held until the current frame ends, so no frame is ever cut short. While the link is stopped the serial data and bit-clock outputs are forced low and all register writes are dropped. Two ways bring the link back: a cold reset from the active-low reset pin, which returns every bit to its default, and a warm reset, which is a long enough high level on the frame-sync input while no bit-clock edges are seen. A warm reset clears only the link-stop bit. Both sync and the bit clock are brought into the local clock domain through synchronizers.

Top module: `codec_pwr_seq`

## Requirements
- R1: While `cold_rst_n` is low at a rising clock edge, the whole status word becomes 0x0000 after that edge, the link runs and every ready bit is low.
- R2: Control bits sit in `reg_wdata[15:8]`: bit 8 stops the ADC (`adc_en` low), bit 9 the DAC (`dac_en` low), bit 10 the mixer (`mix_en` low), bit 13 the internal clocks (`clk_en` low); each takes effect the cycle after the write.
- R3: Bit 11 stops the voltage reference and also the mixer, so `vref_en` and `mix_en` both go low; bit 10 alone leaves `vref_en` high.
- R4: Ready bits are `reg_rdata[0]` ADC, `[1]` DAC, `[2]` mixer, `[3]` reference; a ready bit reads 0 in the same cycle its section's enable is low.
- R5: After a section is enabled again, its ready bit returns `RDY_DLY` cycles later (`VREF_DLY` for the reference) and stays low before that.
- R6: Bit 15 drives `eapd_o` directly; bit 14 and bits 7:4 always read 0 regardless of what is written.
- R7: Writing bit 12 as 1 stops the link only at the next `frame_end` pulse; a write in the same cycle as `frame_end` decides the outcome, so a 1 then stops the link and a 0 then cancels a pending request.
- R8: While the link is stopped, `sdata_o` and `bclk_o` are 0 and register writes are ignored.
- R9: A warm reset (`sync_i` high for at least `WARM_MIN` local clock cycles with no bit-clock edge) clears bit 12 and restarts the link, leaving every other control bit unchanged; a shorter high pulse does nothing.
- R10: Bit-clock edges during a high `sync_i` restart the warm-reset count, so a running bit clock prevents a warm reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running local clock |
| cold_rst_n | input | 1 | Cold reset pin, active low, sampled on `clk` |
| reg_wr | input | 1 | Write strobe for the power-down word |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Status word: control byte, zeros, ready nibble |
| frame_end | input | 1 | One-cycle pulse at the end of each link frame |
| sync_i | input | 1 | Frame-sync input, asynchronous |
| bclk_i | input | 1 | Bit clock from the link clock source |
| sdata_i | input | 1 | Serial data from the slot logic |
| bclk_o | output | 1 | Bit clock to the pin, forced low while the link is stopped |
| sdata_o | output | 1 | Serial data to the pin, forced low while the link is stopped |
| adc_en | output | 1 | ADC path enable |
| dac_en | output | 1 | DAC path enable |
| mix_en | output | 1 | Mixer enable |
| vref_en | output | 1 | Voltage reference enable |
| clk_en | output | 1 | Internal clock enable |
| eapd_o | output | 1 | External amplifier shutdown pin |

## Verification
The collision that matters is a register write landing in the same cycle as the frame-end pulse that commits a pending link stop. The bench drives `reg_wr` and `frame_end` together in one cycle, once with bit 12 set and once with bit 12 clear after an earlier request, and judges by whether `bclk_o` still follows `bclk_i` on the following cycle. A second pairing, warm-reset detection against a running bit clock, is provoked by toggling `bclk_i` under a long `sync_i` pulse and judged by whether the pending request bit survives in `reg_rdata`.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;

    // Control byte as it sits in the upper half of the status word
    typedef struct packed {
        logic eapd;     // external amplifier shutdown
        logic spare;    // unused, always reads 0
        logic clk_off;  // internal clocks stopped
        logic link_off; // serial link stop request
        logic ref_off;  // reference (and mixer) stopped
        logic mix_off;  // mixer stopped
        logic dac_off;  // DAC path stopped
        logic adc_off;  // ADC path stopped
    } pwr_ctl_t;

    localparam int unsigned NUM_SUB = 4;

    typedef enum logic [1:0] {
        SUB_ADC = 2'd0,
        SUB_DAC = 2'd1,
        SUB_MIX = 2'd2,
        SUB_REF = 2'd3
    } sub_e;

    function automatic pwr_ctl_t ctl_from_word(input logic [15:0] w);
        pwr_ctl_t c;
        c       = w[15:8];
        c.spare = 1'b0;
        return c;
    endfunction

    function automatic logic [NUM_SUB-1:0] sub_enables(input pwr_ctl_t c);
        logic [NUM_SUB-1:0] e;
        e[SUB_ADC] = ~c.adc_off;
        e[SUB_DAC] = ~c.dac_off;
        e[SUB_MIX] = ~(c.mix_off | c.ref_off);
        e[SUB_REF] = ~c.ref_off;
        return e;
    endfunction

    function automatic logic [15:0] status_word(input pwr_ctl_t c,
                                                input logic [NUM_SUB-1:0] rdy);
        return {c, 4'b0000, rdy};
    endfunction

endpackage

// File: rtl/ready_timer.sv
module ready_timer #(
    parameter int unsigned DELAY = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic ready
);
    localparam int unsigned CW = $clog2(DELAY + 1);
    localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

    logic [CW-1:0] cnt;
    logic          settled;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt     <= '0;
            settled <= 1'b0;
        end else if (!settled) begin
            if (cnt == LAST) begin
                settled <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // drops in the same cycle the enable falls
    assign ready = settled & en;
endmodule

// File: rtl/warm_rst_det.sv
module warm_rst_det #(
    parameter int unsigned WARM_MIN = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_async,
    input  logic bclk_async,
    output logic warm
);
    localparam int unsigned CW = $clog2(WARM_MIN + 1);
    localparam logic [CW-1:0] LAST = CW'(WARM_MIN - 1);
    localparam logic [CW-1:0] FULL = CW'(WARM_MIN);

    logic [SYNC_STAGES-1:0] sync_pipe;
    logic [SYNC_STAGES:0]   bclk_pipe;
    logic                   sync_s;
    logic                   bclk_edge;
    logic [CW-1:0]          cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_pipe <= '0;
            bclk_pipe <= '0;
        end else begin
            sync_pipe <= {sync_pipe[SYNC_STAGES-2:0], sync_async};
            bclk_pipe <= {bclk_pipe[SYNC_STAGES-1:0], bclk_async};
        end
    end

    assign sync_s    = sync_pipe[SYNC_STAGES-1];
    assign bclk_edge = bclk_pipe[SYNC_STAGES] ^ bclk_pipe[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            warm <= 1'b0;
        end else begin
            warm <= sync_s && !bclk_edge && (cnt == LAST);
            if (!sync_s || bclk_edge) begin
                cnt <= '0;
            end else if (cnt != FULL) begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/pwr_ctl_reg.sv
module pwr_ctl_reg
    import codec_pwr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic [15:0] wdata,
    input  logic        frame_end,
    input  logic        warm,
    output pwr_ctl_t    ctl,
    output logic        link_down
);
    pwr_ctl_t wr_ctl;
    logic     req_now;

    assign wr_ctl  = ctl_from_word(wdata);
    // a write in the frame-end cycle is the newest word and decides
    assign req_now = wr ? wr_ctl.link_off : ctl.link_off;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl       <= '0;
            link_down <= 1'b0;
        end else if (warm) begin
            ctl.link_off <= 1'b0;
            link_down    <= 1'b0;
        end else if (!link_down) begin
            if (wr) begin
                ctl <= wr_ctl;
            end
            if (frame_end) begin
                link_down <= req_now;
            end
        end
    end
endmodule

// File: rtl/codec_pwr_seq.sv
module codec_pwr_seq
    import codec_pwr_pkg::*;
#(
    parameter int unsigned RDY_DLY     = 16,
    parameter int unsigned VREF_DLY    = 64,
    parameter int unsigned WARM_MIN    = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        cold_rst_n,
    input  logic        reg_wr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    input  logic        frame_end,
    input  logic        sync_i,
    input  logic        bclk_i,
    input  logic        sdata_i,
    output logic        bclk_o,
    output logic        sdata_o,
    output logic        adc_en,
    output logic        dac_en,
    output logic        mix_en,
    output logic        vref_en,
    output logic        clk_en,
    output logic        eapd_o
);
    logic               rst;
    pwr_ctl_t           ctl;
    logic               link_down;
    logic               warm_pulse;
    logic [NUM_SUB-1:0] en;
    logic [NUM_SUB-1:0] rdy;

    assign rst = ~cold_rst_n;

    pwr_ctl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr        (reg_wr),
        .wdata     (reg_wdata),
        .frame_end (frame_end),
        .warm      (warm_pulse),
        .ctl       (ctl),
        .link_down (link_down)
    );

    warm_rst_det #(
        .WARM_MIN    (WARM_MIN),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_warm (
        .clk        (clk),
        .rst        (rst),
        .sync_async (sync_i),
        .bclk_async (bclk_o),
        .warm       (warm_pulse)
    );

    assign en = sub_enables(ctl);

    for (genvar i = 0; i < NUM_SUB; i++) begin : g_rdy
        localparam int unsigned DLY = (i == int'(SUB_REF)) ? VREF_DLY : RDY_DLY;
        ready_timer #(.DELAY(DLY)) u_tmr (
            .clk   (clk),
            .rst   (rst),
            .en    (en[i]),
            .ready (rdy[i])
        );
    end

    assign adc_en    = en[SUB_ADC];
    assign dac_en    = en[SUB_DAC];
    assign mix_en    = en[SUB_MIX];
    assign vref_en   = en[SUB_REF];
    assign clk_en    = ~ctl.clk_off;
    assign eapd_o    = ctl.eapd;
    assign bclk_o    = bclk_i & ~link_down;
    assign sdata_o   = sdata_i & ~link_down;
    assign reg_rdata = status_word(ctl, rdy);
endmodule

// File: rtl/codec_pwr_chk.sv
module codec_pwr_chk (
    input logic        clk,
    input logic        cold_rst_n,
    input logic        reg_wr,
    input logic        frame_end,
    input logic [15:0] reg_rdata,
    input logic        link_down,
    input logic        warm,
    input logic        sdata_o,
    input logic        bclk_o,
    input logic        adc_en,
    input logic        dac_en,
    input logic        mix_en,
    input logic        vref_en
);
    assert_cold_defaults_R1: assert property (@(posedge clk)
        !cold_rst_n |=> (reg_rdata[15:8] == 8'h00) && !link_down);

    assert_ref_takes_mixer_R3: assert property (@(posedge clk) disable iff (!cold_rst_n)
        reg_rdata[11] |-> (!mix_en && !vref_en));

    assert_ready_follows_enable_R4: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (!adc_en |-> !reg_rdata[0]) and (!dac_en |-> !reg_rdata[1])
        and (!mix_en |-> !reg_rdata[2]) and (!vref_en |-> !reg_rdata[3]));

    assert_zero_fields_R6: assert property (@(posedge clk) disable iff (!cold_rst_n)
        !reg_rdata[14] && (reg_rdata[7:4] == 4'h0));

    assert_stop_at_frame_end_R7: assert property (@(posedge clk) disable iff (!cold_rst_n)
        $rose(link_down) |-> $past(frame_end));

    assert_pins_quiet_R8: assert property (@(posedge clk) disable iff (!cold_rst_n)
        link_down |-> (!sdata_o && !bclk_o));

    assert_warm_keeps_rest_R9: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (warm && !reg_wr) |=> !link_down && !reg_rdata[12]
            && (reg_rdata[11:8] == $past(reg_rdata[11:8]))
            && (reg_rdata[15:13] == $past(reg_rdata[15:13])));
endmodule

bind codec_pwr_seq codec_pwr_chk u_chk (
    .clk        (clk),
    .cold_rst_n (cold_rst_n),
    .reg_wr     (reg_wr),
    .frame_end  (frame_end),
    .reg_rdata  (reg_rdata),
    .link_down  (link_down),
    .warm       (warm_pulse),
    .sdata_o    (sdata_o),
    .bclk_o     (bclk_o),
    .adc_en     (adc_en),
    .dac_en     (dac_en),
    .mix_en     (mix_en),
    .vref_en    (vref_en)
);

// File: tb/codec_pwr_seq_tb.sv
`timescale 1ns/1ps
module codec_pwr_seq_tb;
    localparam int RDY_DLY  = 16;
    localparam int VREF_DLY = 64;
    localparam int WARM_MIN = 8;

    logic        clk = 1'b0;
    logic        cold_rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        frame_end = 1'b0;
    logic        sync_i = 1'b0;
    logic        bclk_i = 1'b1;
    logic        sdata_i = 1'b1;
    logic        bclk_o, sdata_o, adc_en, dac_en, mix_en, vref_en, clk_en, eapd_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    codec_pwr_seq #(
        .RDY_DLY(RDY_DLY), .VREF_DLY(VREF_DLY), .WARM_MIN(WARM_MIN), .SYNC_STAGES(2)
    ) u_dut (
        .clk(clk), .cold_rst_n(cold_rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .frame_end(frame_end), .sync_i(sync_i), .bclk_i(bclk_i),
        .sdata_i(sdata_i), .bclk_o(bclk_o), .sdata_o(sdata_o), .adc_en(adc_en),
        .dac_en(dac_en), .mix_en(mix_en), .vref_en(vref_en), .clk_en(clk_en),
        .eapd_o(eapd_o)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [15:0] d, input logic fe);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d; frame_end = fe;
        @(negedge clk);
        reg_wr = 1'b0; frame_end = 1'b0;
    endtask

    task automatic pulse_fe();
        @(negedge clk); frame_end = 1'b1;
        @(negedge clk); frame_end = 1'b0;
    endtask

    task automatic hold_sync(input int n, input bit toggle);
        @(negedge clk); sync_i = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (toggle && (i % 2 == 0)) bclk_i = ~bclk_i;
        end
        sync_i = 1'b0; bclk_i = 1'b1;
        idle(4);
    endtask

    task automatic t_reset();
        idle(3); cold_rst_n = 1'b1; @(negedge clk);
        chk("R1 word after reset", reg_rdata, 16'h0000);
        chk("R1 link running", {15'd0, bclk_o}, 16'h1);
        idle(VREF_DLY + 5);
        chk("R5 all ready after settling", reg_rdata, 16'h000F);
    endtask

    task automatic t_enables();
        wr(16'h0100, 1'b0);
        chk("R2 adc off", {12'd0, vref_en, mix_en, dac_en, adc_en}, 16'h000E);
        chk("R4 adc ready drops at once", reg_rdata[3:0], 16'h000E);
        wr(16'h0400, 1'b0);
        chk("R3 mixer alone keeps ref", {12'd0, vref_en, mix_en, dac_en, adc_en}, 16'h000B);
        wr(16'h0800, 1'b0);
        chk("R3 ref takes mixer", {12'd0, vref_en, mix_en, dac_en, adc_en}, 16'h0003);
        chk("R4 ref and mixer ready low", reg_rdata[3:2], 16'h0000);
        wr(16'h2000, 1'b0);
        chk("R2 clocks off", {15'd0, clk_en}, 16'h0000);
    endtask

    task automatic t_ready_timing();
        wr(16'h0000, 1'b0);
        idle(VREF_DLY - 3);
        chk("R5 ref ready still low", {15'd0, reg_rdata[3]}, 16'h0);
        idle(5);
        chk("R5 ref ready back", {15'd0, reg_rdata[3]}, 16'h1);
        wr(16'h0200, 1'b0);
        idle(3);
        wr(16'h0000, 1'b0);
        idle(RDY_DLY - 3);
        chk("R5 dac ready still low", {15'd0, reg_rdata[1]}, 16'h0);
        chk("R5 ref unaffected", {15'd0, reg_rdata[3]}, 16'h1);
        idle(5);
        chk("R5 dac ready back", {15'd0, reg_rdata[1]}, 16'h1);
    endtask

    task automatic t_fields();
        wr(16'hE0F0, 1'b0);
        chk("R6 spare and low bits read zero", {reg_rdata[15:8], 4'h0, reg_rdata[7:4]}, 16'hA000);
        chk("R6 amplifier pin", {15'd0, eapd_o}, 16'h1);
        chk("R2 clocks stopped, bclk running", {14'd0, clk_en, bclk_o}, 16'h0001);
    endtask

    task automatic t_link_stop();
        wr(16'h9100, 1'b0);
        chk("R7 stop deferred", {reg_rdata[15:8], 7'd0, bclk_o}, 16'h9101);
        pulse_fe();
        chk("R8 pins forced low", {14'd0, bclk_o, sdata_o}, 16'h0000);
        wr(16'h0000, 1'b0);
        chk("R8 write ignored while stopped", {8'd0, reg_rdata[15:8]}, 16'h0091);
    endtask

    task automatic t_warm();
        hold_sync(WARM_MIN - 2, 1'b0);
        chk("R9 short sync ignored", {15'd0, bclk_o}, 16'h0);
        hold_sync(WARM_MIN + 6, 1'b0);
        chk("R9 warm restarts link", {15'd0, bclk_o}, 16'h1);
        chk("R9 other bits kept", {8'd0, reg_rdata[15:8]}, 16'h0081);
    endtask

    task automatic t_bclk_block();
        wr(16'h1000, 1'b0);
        hold_sync(WARM_MIN + 8, 1'b1);
        chk("R10 running bclk blocks warm", {15'd0, reg_rdata[12]}, 16'h1);
        hold_sync(WARM_MIN + 6, 1'b0);
        chk("R9 warm clears pending stop", {15'd0, reg_rdata[12]}, 16'h0);
        pulse_fe();
        chk("R9 link stays up after clear", {15'd0, bclk_o}, 16'h1);
    endtask

    task automatic t_collide();
        wr(16'h1000, 1'b1);
        chk("R7 write on frame end stops link", {15'd0, bclk_o}, 16'h0);
        hold_sync(WARM_MIN + 6, 1'b0);
        wr(16'h1000, 1'b0);
        wr(16'h0000, 1'b1);
        chk("R7 write on frame end cancels", {15'd0, bclk_o}, 16'h1);
    endtask

    task automatic t_cold();
        wr(16'h9000, 1'b0);
        pulse_fe();
        chk("R8 stopped before cold reset", {15'd0, bclk_o}, 16'h0);
        @(negedge clk); cold_rst_n = 1'b0;
        @(negedge clk); cold_rst_n = 1'b1;
        @(negedge clk);
        chk("R1 cold reset clears word", reg_rdata, 16'h0000);
        chk("R1 cold reset restarts link", {14'd0, bclk_o, eapd_o}, 16'h0002);
    endtask

    initial begin
        t_reset();
        t_enables();
        t_ready_timing();
        t_fields();
        t_link_stop();
        t_warm();
        t_bclk_block();
        t_collide();
        t_cold();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        idle(20000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule